// File: doc/BRIEF.md
# Flash Command Unlock Sequencer

This block sits between the register bus of a small processor and the command port of an on-chip flash array. Destructive array operations are only released after a fixed ritual. Software first writes a page number. It then writes two key bytes to the control register, and then writes the same page number again. The frequency value must already be non-zero. The selected page must also lie inside the array and outside every protected sector. When all of this holds, the sequencer opens that single page for byte programming or page erase. When no sector is protected, it also allows a mass erase. Any write that breaks the ritual drops the sequencer back to the locked state.

Erase and program requests become one-cycle strobes on the array port, with the target address attached. The block then tracks the array's busy line. Register writes are held off until the operation ends. An erase closes the page again once the array finishes. A byte program leaves the page open, so that further bytes of the same page can follow.

The page register and the sector-protect mask share one register address. A dedicated control code chooses which of the two that address reaches. Protect bits can be set but never cleared until the next reset.

Top module: `flash_unlock_seq`

## Requirements
- R1: After reset, the status reads 00h, the page reads 00h, the frequency reads 0000h, the protect mask is 00h, and no array strobe is active.
- R2: Reading register 0 returns the lock state code in bits [1:0] (0 locked, 1 first key seen, 2 second key seen, 3 page open) and the busy flag in bit 7. All other bits read zero.
- R3: Writing 73h and then 8Ch to register 0 advances the state from locked through 1 to 2. Any other write while in state 1 or state 2 returns the state to locked; this includes a wrong value or a write to a different register.
- R4: In state 2, a write to register 1 (page selected) moves the state to 3 only when all of these hold: the written value equals the held page, the page is below 16, the page's sector is not protected, and the frequency (register 2 = high byte, register 3 = low byte) is non-zero. Otherwise the state returns to locked.
- R5: Writing 95h to register 0 in state 3 raises the page-erase strobe for exactly one cycle, with address = page × 512. Busy is set from that cycle until the array has raised and then dropped its busy line, after which the state becomes locked.
- R6: Writing 63h to register 0 in state 3 with an all-zero protect mask raises the mass-erase strobe for one cycle and relocks when the array finishes. With any protect bit set, the same write relocks without a strobe.
- R7: In state 3, while not busy, a program-port write whose address bits [15:9] equal the page raises the program strobe for one cycle, with that address and data. The state stays 3 after the array finishes. A program write outside the page gives no strobe.
- R8: Writing 5Eh to register 0 routes register 1 to the protect mask; any other write to register 0 routes it back to the page. Mask writes OR into the mask, so bits are never cleared. Bit i protects pages 2i and 2i+1.
- R9: The frequency is written and read back as two bytes, at register 2 (high) and register 3 (low).
- R10: While busy, register writes have no effect on any register or on the lock state, and they issue no strobe.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | 2 | Register select: 0 control/status, 1 page/protect, 2 frequency high, 3 frequency low |
| reg_wdata | input | 8 | Register write data |
| reg_rdata | output | 8 | Register read data for reg_addr |
| pm_wr | input | 1 | Program-memory byte write request |
| pm_addr | input | ADDR_W | Program-memory byte address |
| pm_wdata | input | 8 | Program-memory byte data |
| fl_page_erase | output | 1 | One-cycle page erase command to the array |
| fl_mass_erase | output | 1 | One-cycle mass erase command to the array |
| fl_prog | output | 1 | One-cycle byte program command to the array |
| fl_addr | output | ADDR_W | Address attached to the command |
| fl_wdata | output | 8 | Data attached to a program command |
| fl_busy | input | 1 | Array is executing a command |

## Verification
The bench builds the block with its default values: a 16-bit address, 7-bit page, 16 pages and two pages per sector. With these values, the out-of-range page (10h), pages in the same protected sector, and a fully clear protect mask for mass erase are all reachable in a few writes. Its array model holds busy for six cycles after each command. This leaves room to write to the registers during an operation and to check that those writes are ignored.

// File: rtl/fc_pkg.sv
package fc_pkg;
  typedef enum logic [1:0] {
    ST_LOCKED = 2'd0,
    ST_KEY1   = 2'd1,
    ST_KEY2   = 2'd2,
    ST_OPEN   = 2'd3
  } lock_st_t;

  typedef enum logic [1:0] {
    RA_CTRL = 2'd0,
    RA_PAGE = 2'd1,
    RA_FHI  = 2'd2,
    RA_FLO  = 2'd3
  } reg_addr_t;

  localparam logic [7:0] KEY_FIRST      = 8'h73;
  localparam logic [7:0] KEY_SECOND     = 8'h8C;
  localparam logic [7:0] CMD_PAGE_ERASE = 8'h95;
  localparam logic [7:0] CMD_MASS_ERASE = 8'h63;
  localparam logic [7:0] CMD_PROT_SEL   = 8'h5E;
endpackage

// File: rtl/fc_cfg_regs.sv
module fc_cfg_regs
  import fc_pkg::*;
#(
  parameter int PAGE_W   = 7,
  parameter int NUM_SECT = 8,
  parameter int FREQ_W   = 16
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                wr_ok,
  input  logic [1:0]          addr,
  input  logic [7:0]          wdata,
  output logic [PAGE_W-1:0]   page_q,
  output logic [NUM_SECT-1:0] prot_q,
  output logic [FREQ_W-1:0]   freq_q,
  output logic                psel_q
);
  localparam int LO_W = 8;
  localparam int HI_W = FREQ_W - LO_W;

  logic [PAGE_W-1:0]   page_d;
  logic [NUM_SECT-1:0] prot_d;
  logic [FREQ_W-1:0]   freq_d;
  logic                psel_d;
  logic                cfg_en;

  always_comb begin
    page_d = page_q;
    prot_d = prot_q;
    freq_d = freq_q;
    psel_d = psel_q;
    if (wr_ok) begin
      unique case (reg_addr_t'(addr))
        RA_CTRL: psel_d = (wdata == CMD_PROT_SEL);
        RA_PAGE: begin
          if (psel_q) prot_d = prot_q | wdata[NUM_SECT-1:0];
          else        page_d = wdata[PAGE_W-1:0];
        end
        RA_FHI:  freq_d[FREQ_W-1:LO_W] = wdata[HI_W-1:0];
        RA_FLO:  freq_d[LO_W-1:0] = wdata;
        default: ;
      endcase
    end
  end

  assign cfg_en = wr_ok;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      page_q <= '0;
      prot_q <= '0;
      freq_q <= '0;
      psel_q <= 1'b0;
    end else if (cfg_en) begin
      page_q <= page_d;
      prot_q <= prot_d;
      freq_q <= freq_d;
      psel_q <= psel_d;
    end
  end
endmodule

// File: rtl/fc_lock_fsm.sv
module fc_lock_fsm
  import fc_pkg::*;
#(
  parameter int PAGE_W = 7
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_ok,
  input  logic [1:0]        addr,
  input  logic [7:0]        wdata,
  input  logic [PAGE_W-1:0] page_q,
  input  logic              psel_q,
  input  logic              unlock_ok,
  input  logic              prot_any,
  input  logic              op_done,
  input  logic              op_erase,
  output lock_st_t          st_q,
  output logic              start_pe,
  output logic              start_me
);
  lock_st_t st_d;
  logic     is_ctrl;
  logic     is_page;
  logic     page_match;

  assign is_ctrl    = (reg_addr_t'(addr) == RA_CTRL);
  assign is_page    = (reg_addr_t'(addr) == RA_PAGE);
  assign page_match = (wdata == 8'(page_q));

  always_comb begin
    st_d     = st_q;
    start_pe = 1'b0;
    start_me = 1'b0;
    unique case (st_q)
      ST_LOCKED: begin
        if (wr_ok && is_ctrl && (wdata == KEY_FIRST)) st_d = ST_KEY1;
      end
      ST_KEY1: begin
        if (wr_ok) st_d = (is_ctrl && (wdata == KEY_SECOND)) ? ST_KEY2 : ST_LOCKED;
      end
      ST_KEY2: begin
        if (wr_ok)
          st_d = (is_page && !psel_q && page_match && unlock_ok) ? ST_OPEN : ST_LOCKED;
      end
      ST_OPEN: begin
        if (op_done && op_erase) begin
          st_d = ST_LOCKED;
        end else if (wr_ok) begin
          if (is_ctrl && (wdata == CMD_PAGE_ERASE))                  start_pe = 1'b1;
          else if (is_ctrl && (wdata == CMD_MASS_ERASE) && !prot_any) start_me = 1'b1;
          else                                                         st_d = ST_LOCKED;
        end
      end
      default: st_d = ST_LOCKED;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) st_q <= ST_LOCKED;
    else        st_q <= st_d;
  end
endmodule

// File: rtl/fc_op_ctrl.sv
module fc_op_ctrl #(
  parameter int ADDR_W = 16,
  parameter int PAGE_W = 7
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start_pe,
  input  logic              start_me,
  input  logic              start_pg,
  input  logic [PAGE_W-1:0] page_q,
  input  logic [ADDR_W-1:0] pm_addr,
  input  logic [7:0]        pm_wdata,
  input  logic              fl_busy,
  output logic              fl_page_erase,
  output logic              fl_mass_erase,
  output logic              fl_prog,
  output logic [ADDR_W-1:0] fl_addr,
  output logic [7:0]        fl_wdata,
  output logic              busy,
  output logic              op_done,
  output logic              op_erase
);
  localparam int OFS_W = ADDR_W - PAGE_W;

  logic              act_q, act_d;
  logic              seen_q, seen_d;
  logic              erase_q, erase_d;
  logic [ADDR_W-1:0] addr_d;
  logic [7:0]        data_d;
  logic              start_any;
  logic              cmd_en;

  assign start_any = start_pe | start_me | start_pg;
  assign op_done   = act_q && seen_q && !fl_busy;
  assign busy      = act_q;
  assign op_erase  = erase_q;
  assign cmd_en    = start_any;

  always_comb begin
    act_d   = act_q;
    seen_d  = seen_q;
    erase_d = erase_q;
    addr_d  = fl_addr;
    data_d  = fl_wdata;
    if (start_pe) addr_d = {page_q, {OFS_W{1'b0}}};
    if (start_me) addr_d = '0;
    if (start_pg) begin
      addr_d = pm_addr;
      data_d = pm_wdata;
    end
    if (start_any) begin
      act_d   = 1'b1;
      seen_d  = 1'b0;
      erase_d = !start_pg;
    end else if (op_done) begin
      act_d  = 1'b0;
      seen_d = 1'b0;
    end else if (act_q && fl_busy) begin
      seen_d = 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      act_q         <= 1'b0;
      seen_q        <= 1'b0;
      erase_q       <= 1'b0;
      fl_page_erase <= 1'b0;
      fl_mass_erase <= 1'b0;
      fl_prog       <= 1'b0;
    end else begin
      act_q         <= act_d;
      seen_q        <= seen_d;
      erase_q       <= erase_d;
      fl_page_erase <= start_pe;
      fl_mass_erase <= start_me;
      fl_prog       <= start_pg;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      fl_addr  <= '0;
      fl_wdata <= '0;
    end else if (cmd_en) begin
      fl_addr  <= addr_d;
      fl_wdata <= data_d;
    end
  end
endmodule

// File: rtl/flash_unlock_seq.sv
module flash_unlock_seq
  import fc_pkg::*;
#(
  parameter int ADDR_W       = 16,
  parameter int PAGE_W       = 7,
  parameter int ARRAY_PAGES  = 16,
  parameter int SECTOR_PAGES = 2,
  parameter int FREQ_W       = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              reg_wr,
  input  logic [1:0]        reg_addr,
  input  logic [7:0]        reg_wdata,
  output logic [7:0]        reg_rdata,
  input  logic              pm_wr,
  input  logic [ADDR_W-1:0] pm_addr,
  input  logic [7:0]        pm_wdata,
  output logic              fl_page_erase,
  output logic              fl_mass_erase,
  output logic              fl_prog,
  output logic [ADDR_W-1:0] fl_addr,
  output logic [7:0]        fl_wdata,
  input  logic              fl_busy
);
  localparam int OFS_W    = ADDR_W - PAGE_W;
  localparam int NUM_SECT = ARRAY_PAGES / SECTOR_PAGES;
  localparam int SECT_SH  = $clog2(SECTOR_PAGES);

  logic [1:0]          rst_pipe;
  logic                rst_q;
  logic [PAGE_W-1:0]   page_q;
  logic [NUM_SECT-1:0] prot_q;
  logic [FREQ_W-1:0]   freq_q;
  logic                psel_q;
  lock_st_t            st_q;
  logic                busy_w;
  logic                wr_ok;
  logic                start_pe, start_me, start_pg;
  logic                op_done, op_erase;
  logic                page_legal, prot_hit, unlock_ok, prot_any;
  logic [NUM_SECT-1:0] hit_vec;

  // asynchronous assertion, synchronous release
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_pipe <= 2'b00;
    else        rst_pipe <= {rst_pipe[0], 1'b1};
  end
  assign rst_q = rst_pipe[1];

  assign wr_ok = reg_wr && !busy_w;

  fc_cfg_regs #(.PAGE_W(PAGE_W), .NUM_SECT(NUM_SECT), .FREQ_W(FREQ_W)) u_regs (
    .clk(clk), .rst_n(rst_q), .wr_ok(wr_ok), .addr(reg_addr), .wdata(reg_wdata),
    .page_q(page_q), .prot_q(prot_q), .freq_q(freq_q), .psel_q(psel_q)
  );

  // one comparator per sector against the held page
  for (genvar s = 0; s < NUM_SECT; s++) begin : g_sect
    assign hit_vec[s] = prot_q[s] && ((page_q >> SECT_SH) == PAGE_W'(s));
  end

  assign page_legal = ({1'b0, page_q} < (PAGE_W + 1)'(ARRAY_PAGES));
  assign prot_hit   = |hit_vec;
  assign prot_any   = |prot_q;
  assign unlock_ok  = page_legal && !prot_hit && (|freq_q);

  fc_lock_fsm #(.PAGE_W(PAGE_W)) u_fsm (
    .clk(clk), .rst_n(rst_q), .wr_ok(wr_ok), .addr(reg_addr), .wdata(reg_wdata),
    .page_q(page_q), .psel_q(psel_q), .unlock_ok(unlock_ok), .prot_any(prot_any),
    .op_done(op_done), .op_erase(op_erase), .st_q(st_q),
    .start_pe(start_pe), .start_me(start_me)
  );

  assign start_pg = (st_q == ST_OPEN) && !busy_w && pm_wr && !reg_wr &&
                    (pm_addr[ADDR_W-1:OFS_W] == page_q);

  fc_op_ctrl #(.ADDR_W(ADDR_W), .PAGE_W(PAGE_W)) u_op (
    .clk(clk), .rst_n(rst_q), .start_pe(start_pe), .start_me(start_me),
    .start_pg(start_pg), .page_q(page_q), .pm_addr(pm_addr), .pm_wdata(pm_wdata),
    .fl_busy(fl_busy), .fl_page_erase(fl_page_erase), .fl_mass_erase(fl_mass_erase),
    .fl_prog(fl_prog), .fl_addr(fl_addr), .fl_wdata(fl_wdata),
    .busy(busy_w), .op_done(op_done), .op_erase(op_erase)
  );

  always_comb begin
    unique case (reg_addr_t'(reg_addr))
      RA_CTRL: reg_rdata = {busy_w, 5'b0, st_q};
      RA_PAGE: reg_rdata = psel_q ? 8'(prot_q) : 8'(page_q);
      RA_FHI:  reg_rdata = freq_q[FREQ_W-1:8];
      RA_FLO:  reg_rdata = freq_q[7:0];
      default: reg_rdata = 8'h00;
    endcase
  end
endmodule

// File: rtl/fc_unlock_chk.sv
module fc_unlock_chk #(
  parameter int ADDR_W   = 16,
  parameter int PAGE_W   = 7,
  parameter int NUM_SECT = 8
) (
  input logic                clk,
  input logic                rst_q,
  input logic [1:0]          state,
  input logic [NUM_SECT-1:0] prot,
  input logic                busy,
  input logic                pe,
  input logic                me,
  input logic                pg,
  input logic [ADDR_W-1:0]   addr
);
  localparam int OFS_W = ADDR_W - PAGE_W;

  AST_KEY2_AFTER_KEY1: assert property (@(posedge clk) disable iff (!rst_q)
    (state == 2'd2 && $past(state) != 2'd2) |-> ($past(state) == 2'd1)); // R3
  AST_OPEN_AFTER_KEY2: assert property (@(posedge clk) disable iff (!rst_q)
    (state == 2'd3 && $past(state) != 2'd3) |-> ($past(state) == 2'd2)); // R4
  AST_STROBE_ONEHOT: assert property (@(posedge clk) disable iff (!rst_q)
    $onehot0({pe, me, pg})); // R5
  AST_ERASE_PULSE: assert property (@(posedge clk) disable iff (!rst_q)
    pe |=> !pe); // R5
  AST_ERASE_ALIGNED: assert property (@(posedge clk) disable iff (!rst_q)
    pe |-> (addr[OFS_W-1:0] == '0)); // R5
  AST_MASS_UNPROTECTED: assert property (@(posedge clk) disable iff (!rst_q)
    me |-> (prot == '0)); // R6
  AST_STROBE_WHEN_OPEN: assert property (@(posedge clk) disable iff (!rst_q)
    (pe | me | pg) |-> (state == 2'd3)); // R7
  AST_PROT_STICKY: assert property (@(posedge clk) disable iff (!rst_q)
    ((prot & $past(prot)) == $past(prot))); // R8
  AST_BUSY_WITH_STROBE: assert property (@(posedge clk) disable iff (!rst_q)
    (pe | me | pg) |-> busy); // R10
endmodule

bind flash_unlock_seq fc_unlock_chk #(
  .ADDR_W(ADDR_W), .PAGE_W(PAGE_W), .NUM_SECT(ARRAY_PAGES / SECTOR_PAGES)
) u_chk (
  .clk(clk), .rst_q(rst_q), .state(st_q), .prot(prot_q), .busy(busy_w),
  .pe(fl_page_erase), .me(fl_mass_erase), .pg(fl_prog), .addr(fl_addr)
);

// File: tb/flash_unlock_seq_bench.sv
`timescale 1ns/1ps
module flash_unlock_seq_bench;
  localparam int BUSY_CYC = 6;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        reg_wr = 1'b0;
  logic [1:0]  reg_addr = 2'd0;
  logic [7:0]  reg_wdata = 8'h00;
  logic [7:0]  reg_rdata;
  logic        pm_wr = 1'b0;
  logic [15:0] pm_addr = 16'h0;
  logic [7:0]  pm_wdata = 8'h00;
  logic        fl_page_erase, fl_mass_erase, fl_prog;
  logic [15:0] fl_addr;
  logic [7:0]  fl_wdata;
  logic        fl_busy;

  int checks = 0;
  int errors = 0;
  int cycles = 0;
  int n_pe = 0, n_me = 0, n_pg = 0;
  int last_addr = 0, last_data = 0;
  int busy_cnt;

  always #2 clk = ~clk;

  flash_unlock_seq u_flash_unlock_seq (
    .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .pm_wr(pm_wr), .pm_addr(pm_addr),
    .pm_wdata(pm_wdata), .fl_page_erase(fl_page_erase), .fl_mass_erase(fl_mass_erase),
    .fl_prog(fl_prog), .fl_addr(fl_addr), .fl_wdata(fl_wdata), .fl_busy(fl_busy)
  );

  // array model: busy for BUSY_CYC cycles after any command
  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) busy_cnt <= 0;
    else if (fl_page_erase || fl_mass_erase || fl_prog) busy_cnt <= BUSY_CYC;
    else if (busy_cnt != 0) busy_cnt <= busy_cnt - 1;
  end
  assign fl_busy = (busy_cnt != 0);

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
    end
  endtask

  // behavioural reference model
  int m_state, m_page, m_prot, m_freq, m_psel, m_act, m_seen, m_erase;
  int e_pe, e_me, e_pg, e_addr, e_data;
  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_state <= 0; m_page <= 0; m_prot <= 0; m_freq <= 0; m_psel <= 0;
      m_act <= 0; m_seen <= 0; m_erase <= 0;
      e_pe <= 0; e_me <= 0; e_pg <= 0; e_addr <= 0; e_data <= 0;
    end else begin
      bit done, wrk, go_pe, go_me, go_pg;
      int nst;
      done = (m_act != 0) && (m_seen != 0) && !fl_busy;
      wrk  = reg_wr && (m_act == 0);
      go_pe = 0; go_me = 0; go_pg = 0;
      nst = m_state;
      if (wrk) begin
        case (reg_addr)
          2'd0: m_psel <= (reg_wdata == 8'h5E);
          2'd1: if (m_psel != 0) m_prot <= m_prot | reg_wdata;
                else m_page <= reg_wdata & 8'h7F;
          2'd2: m_freq <= (m_freq & 16'h00FF) | (reg_wdata << 8);
          default: m_freq <= (m_freq & 16'hFF00) | reg_wdata;
        endcase
      end
      case (m_state)
        0: if (wrk && reg_addr == 0 && reg_wdata == 8'h73) nst = 1;
        1: if (wrk) nst = (reg_addr == 0 && reg_wdata == 8'h8C) ? 2 : 0;
        2: if (wrk) nst = (reg_addr == 1 && m_psel == 0 && reg_wdata == m_page &&
                           m_page < 16 && ((m_prot >> (m_page / 2)) & 1) == 0 &&
                           m_freq != 0) ? 3 : 0;
        default: begin
          if (done && m_erase != 0) nst = 0;
          else if (wrk) begin
            if (reg_addr == 0 && reg_wdata == 8'h95) go_pe = 1;
            else if (reg_addr == 0 && reg_wdata == 8'h63 && m_prot == 0) go_me = 1;
            else nst = 0;
          end
        end
      endcase
      if (m_state == 3 && m_act == 0 && pm_wr && !reg_wr && (pm_addr >> 9) == m_page)
        go_pg = 1;
      m_state <= nst;
      e_pe <= go_pe; e_me <= go_me; e_pg <= go_pg;
      if (go_pe) e_addr <= m_page * 512;
      if (go_me) e_addr <= 0;
      if (go_pg) begin e_addr <= pm_addr; e_data <= pm_wdata; end
      if (go_pe || go_me || go_pg) begin
        m_act <= 1; m_seen <= 0; m_erase <= !go_pg;
      end else if (done) begin
        m_act <= 0; m_seen <= 0;
      end else if (m_act != 0 && fl_busy) m_seen <= 1;
    end
  end

  function automatic int exp_rdata(input int a);
    case (a)
      0: return (m_act << 7) | m_state;
      1: return (m_psel != 0) ? m_prot : m_page;
      2: return (m_freq >> 8) & 8'hFF;
      default: return m_freq & 8'hFF;
    endcase
  endfunction

  // per-cycle comparison and strobe monitors
  always @(negedge clk) begin
    if (rst_n) begin
      chk(reg_rdata == exp_rdata(reg_addr), "R2 model rdata", reg_rdata, exp_rdata(reg_addr));
      chk({fl_page_erase, fl_mass_erase, fl_prog} == {e_pe[0], e_me[0], e_pg[0]},
          "R5 model strobes", {fl_page_erase, fl_mass_erase, fl_prog}, {e_pe[0], e_me[0], e_pg[0]});
      if (fl_page_erase || fl_mass_erase || fl_prog)
        chk(fl_addr == e_addr[15:0], "R7 model fl_addr", fl_addr, e_addr);
      if (fl_prog) chk(fl_wdata == e_data[7:0], "R7 model fl_wdata", fl_wdata, e_data);
    end
    if (fl_page_erase) begin n_pe++; last_addr = fl_addr; end
    if (fl_mass_erase) begin n_me++; last_addr = fl_addr; end
    if (fl_prog) begin n_pg++; last_addr = fl_addr; last_data = fl_wdata; end
  end

  task automatic wr(input int a, input int d);
    @(posedge clk); #1;
    reg_addr = 2'(a); reg_wdata = 8'(d); reg_wr = 1'b1;
    @(posedge clk); #1;
    reg_wr = 1'b0;
  endtask

  task automatic pm_write(input int a, input int d);
    @(posedge clk); #1;
    pm_addr = 16'(a); pm_wdata = 8'(d); pm_wr = 1'b1;
    @(posedge clk); #1;
    pm_wr = 1'b0;
  endtask

  task automatic rd_chk(input int a, input int exp, input string tag);
    @(posedge clk); #1;
    reg_addr = 2'(a);
    @(negedge clk);
    chk(reg_rdata == 8'(exp), tag, reg_rdata, exp);
  endtask

  task automatic unlock(input int p);
    wr(1, p); wr(0, 8'h73); wr(0, 8'h8C); wr(1, p);
  endtask

  task automatic wait_idle();
    @(posedge clk); #1;
    reg_addr = 2'd0;
    for (int i = 0; i < 100; i++) begin
      @(negedge clk);
      if (!reg_rdata[7]) break;
    end
  endtask

  always @(posedge clk) begin
    cycles++;
    if (cycles > 150000) begin
      errors++;
      $display("FAIL watchdog: actual %0d expected %0d", cycles, 150000);
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (3) @(posedge clk);
    #1 rst_n = 1'b1;
    repeat (4) @(posedge clk);
    // R1 reset state
    rd_chk(0, 8'h00, "R1 status after reset");
    rd_chk(1, 8'h00, "R1 page after reset");
    rd_chk(2, 8'h00, "R1 freq high after reset");
    chk(n_pe + n_me + n_pg == 0, "R1 no strobes", n_pe + n_me + n_pg, 0);
    // R4 zero frequency blocks unlock
    unlock(1);
    rd_chk(0, 8'h00, "R4 zero freq stays locked");
    // R9 frequency bytes
    wr(2, 8'h12); wr(3, 8'h34);
    rd_chk(2, 8'h12, "R9 freq high");
    rd_chk(3, 8'h34, "R9 freq low");
    // R3 key progression and R4 open
    wr(1, 3); wr(0, 8'h73);
    rd_chk(0, 8'h01, "R3 first key");
    wr(0, 8'h8C);
    rd_chk(0, 8'h02, "R3 second key");
    wr(1, 3);
    rd_chk(0, 8'h03, "R4 matching page opens");
    wr(0, 8'h00);
    rd_chk(0, 8'h00, "R3 stray control write relocks");
    wr(0, 8'h73); wr(3, 8'h34);
    rd_chk(0, 8'h00, "R3 other register write relocks");
    wr(0, 8'h73); wr(0, 8'h73);
    rd_chk(0, 8'h00, "R3 repeated first key relocks");
    // R4 mismatch and out-of-range page
    wr(1, 3); wr(0, 8'h73); wr(0, 8'h8C); wr(1, 4);
    rd_chk(0, 8'h00, "R4 page mismatch");
    unlock(8'h10);
    rd_chk(0, 8'h00, "R4 page out of range");
    // R7 programming
    unlock(3);
    rd_chk(0, 8'h03, "R4 page 3 opens");
    pm_write(16'h0605, 8'hA5);
    wait_idle();
    chk(n_pg == 1 && last_addr == 16'h0605 && last_data == 8'hA5, "R7 program strobe",
        last_addr, 16'h0605);
    rd_chk(0, 8'h03, "R7 stays open after program");
    pm_write(16'h0800, 8'h11);
    repeat (2) @(posedge clk);
    chk(n_pg == 1, "R7 outside page ignored", n_pg, 1);
    // R10 writes while busy
    pm_write(16'h0610, 8'h5A);
    wr(0, 8'h95); wr(3, 8'h00);
    wait_idle();
    chk(n_pe == 0, "R10 erase ignored while busy", n_pe, 0);
    rd_chk(0, 8'h03, "R10 state kept while busy");
    rd_chk(3, 8'h34, "R10 freq kept while busy");
    // R5 page erase
    wr(0, 8'h95);
    rd_chk(0, 8'h83, "R5 busy during erase");
    wait_idle();
    chk(n_pe == 1 && last_addr == 16'h0600, "R5 erase address", last_addr, 16'h0600);
    rd_chk(0, 8'h00, "R5 relock after erase");
    // R6 mass erase
    unlock(5);
    wr(0, 8'h63);
    wait_idle();
    chk(n_me == 1 && last_addr == 0, "R6 mass erase strobe", n_me, 1);
    rd_chk(0, 8'h00, "R6 relock after mass erase");
    // R8 protect register
    wr(0, 8'h5E); wr(1, 8'h02);
    rd_chk(1, 8'h02, "R8 protect set");
    wr(1, 8'h00);
    rd_chk(1, 8'h02, "R8 protect not cleared");
    wr(1, 8'h10);
    rd_chk(1, 8'h12, "R8 protect accumulates");
    wr(0, 8'h00);
    rd_chk(1, 8'h05, "R8 page view restored");
    unlock(3);
    rd_chk(0, 8'h00, "R4 protected sector page 3");
    unlock(2);
    rd_chk(0, 8'h00, "R8 sector covers page 2");
    unlock(0);
    rd_chk(0, 8'h03, "R4 unprotected page opens");
    wr(0, 8'h63);
    repeat (3) @(posedge clk);
    chk(n_me == 1, "R6 mass erase refused with protect", n_me, 1);
    rd_chk(0, 8'h00, "R6 refused mass erase relocks");
    repeat (4) @(posedge clk);
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule